// File: doc/BRIEF.md
# Sliding-Window Fundamental Phasor Estimator

This block tracks the fundamental-frequency phasor of one sampled channel. The window covers exactly one nominal cycle of `N` samples. It does not recompute the whole transform on each sample. Instead it corrects the previous estimate:

- The sample leaving the window is subtracted from the newest sample.
- That difference is multiplied by the cosine and sine coefficients for the current slot.
- The two products are added into two running accumulators.

Each update therefore costs two multiplies and two additions, whatever the window length.

For every accepted sample the block outputs the real part, the imaginary part and the squared magnitude of the phasor. It never takes a square root. A boxcar average of the squared magnitude over the last half cycle (`N/2` estimates) follows. It damps the ripple that appears when the grid frequency is not exactly nominal.

A synchronous clear input restarts the estimator from an empty window in a single cycle. It is intended for use when the sampling stream restarts.

Top module: `slidingPhasor`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `phasorValid` and `avgValid` are 0, and `phasorRe`, `phasorIm`, `magSq` and `avgMagSq` are 0.
- R2: Accepted samples are numbered from 0 after reset or clear, and sample number n occupies slot k = n mod N. `phasorRe` equals the sum, over the last N accepted samples, of x·C[k]. Here C[k] is the nearest integer to 32767·cos(2πk/N), and missing samples count as 0.
- R3: `phasorIm` equals the negated sum, over the same window, of x·S[k]. Here S[k] is the nearest integer to 32767·sin(2πk/N).
- R4: `magSq` equals `phasorRe`² + `phasorIm`² exactly, as an unsigned value.
- R5: A sample is accepted when `sampleValid` is 1 and `clear` is 0 at a rising edge. Its results appear, with `phasorValid` high for one cycle, after the second rising edge that follows the accepting edge. Samples may arrive on every cycle.
- R6: While `sampleValid` is 0, the value on `sampleIn` has no effect: no `phasorValid` pulse occurs and all outputs hold.
- R7: One cycle after each `phasorValid` pulse, `avgMagSq` becomes floor(sum of the last N/2 `magSq` values / (N/2)), counting missing values as 0. It changes at no other time except on clear.
- R8: `avgValid` pulses in the cycle that follows the `phasorValid` of sample number N+N/2−1 (the 768th sample at the defaults) and of every later sample, and it is 0 otherwise.
- R9: When `clear` is 1 at a rising edge, the window, the accumulators, the average history and the sample count are emptied in that cycle. Any sample offered in the same cycle is dropped, samples still in flight produce no output, and all outputs read 0 afterwards.
- R10: With full-scale input (−32768 or +32767, signed 16 bit), the results of R2 to R4 stay exact: no accumulator wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart of the estimator |
| sampleValid | input | 1 | `sampleIn` holds a new sample |
| sampleIn | input | 16 | Signed sample |
| phasorValid | output | 1 | One-cycle pulse: the phasor outputs are updated |
| phasorRe | output | 40 | Signed real part |
| phasorIm | output | 40 | Signed imaginary part |
| magSq | output | 80 | Unsigned squared magnitude |
| avgValid | output | 1 | One-cycle pulse: the average is updated and the window is full |
| avgMagSq | output | 80 | Half-cycle average of the squared magnitude |

## Verification
The timing properties assume that `clear` is not asserted while a sample is between the accepting edge and its output. The stimulus only restarts the block after several idle cycles, and one directed case offers a sample in the same cycle as the clear.

The accumulator bound assumes a signed 16-bit input. Random values cover the full code range, and a directed run feeds the extreme codes, aligned in sign with the cosine table, for a whole window. Some samples arrive back to back and some after random idle gaps that carry garbage on `sampleIn`, so that both the full-throughput timing and the hold behaviour are exercised.

// File: rtl/phasorPkg.sv
`timescale 1ns/1ps
package phasorPkg;

  typedef struct packed {
    logic take;   // stage 1: accept sample, fetch oldest
    logic acc;    // stage 2: recursive accumulate
    logic mag;    // stage 3: publish phasor and squared magnitude
    logic avg;    // stage 4: boxcar update
    logic avgOk;  // stage 4 result comes from a full window
    logic clr;    // synchronous restart
  } strobe_t;

  function automatic int quantCoef(real v, int scale);
    real s;
    s = v * scale;
    if (s >= 0.0) return $rtoi(s + 0.5);
    return -$rtoi(-s + 0.5);
  endfunction

endpackage

// File: rtl/phasorRom.sv
`timescale 1ns/1ps
module phasorRom #(
  parameter int N      = 512,
  parameter int COEF_W = 16,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic [IDX_W-1:0]         idx,
  output logic signed [COEF_W-1:0] cosVal,
  output logic signed [COEF_W-1:0] sinVal
);
  localparam int  SCALE  = 2 ** (COEF_W - 1) - 1;
  localparam real TWO_PI = 6.283185307179586;

  logic signed [COEF_W-1:0] cosTab [N];
  logic signed [COEF_W-1:0] sinTab [N];

  for (genvar k = 0; k < N; k++) begin : g_coef
    localparam real ANG = TWO_PI * k / N;
    assign cosTab[k] = COEF_W'(phasorPkg::quantCoef($cos(ANG), SCALE));
    assign sinTab[k] = COEF_W'(phasorPkg::quantCoef($sin(ANG), SCALE));
  end

  assign cosVal = cosTab[idx];
  assign sinVal = sinTab[idx];
endmodule

// File: rtl/phasorCtrl.sv
`timescale 1ns/1ps
module phasorCtrl #(
  parameter int N       = 512,
  parameter int AVG_LEN = 256,
  parameter int IDX_W   = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clear,
  input  logic                 sampleValid,
  output phasorPkg::strobe_t   strobes,
  output logic [IDX_W-1:0]     wrPtr
);
  localparam int FULL_CNT = N + AVG_LEN;
  localparam int CNT_W    = $clog2(FULL_CNT + 1);

  logic [CNT_W-1:0] sampCnt;
  logic v1, v2, v3;
  logic f1, f2, f3;
  logic take;

  assign take = sampleValid & ~clear;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0; sampCnt <= '0;
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      f1 <= 1'b0; f2 <= 1'b0; f3 <= 1'b0;
    end else if (clear) begin
      wrPtr <= '0; sampCnt <= '0;
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      f1 <= 1'b0; f2 <= 1'b0; f3 <= 1'b0;
    end else begin
      v1 <= take; v2 <= v1; v3 <= v2;
      f2 <= f1;   f3 <= f2;
      if (take) begin
        wrPtr <= wrPtr + 1'b1;
        f1    <= (sampCnt >= CNT_W'(FULL_CNT - 1));
        if (sampCnt != CNT_W'(FULL_CNT)) sampCnt <= sampCnt + 1'b1;
      end
    end
  end

  assign strobes.take  = take;
  assign strobes.acc   = v1;
  assign strobes.mag   = v2;
  assign strobes.avg   = v3;
  assign strobes.avgOk = f3;
  assign strobes.clr   = clear;

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampCnt <= CNT_W'(FULL_CNT));
endmodule

// File: rtl/phasorDatapath.sv
`timescale 1ns/1ps
module phasorDatapath #(
  parameter int N        = 512,
  parameter int AVG_LEN  = 256,
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 16,
  parameter int IDX_W    = $clog2(N),
  parameter int ACC_W    = SAMPLE_W + COEF_W + IDX_W - 1,
  parameter int MAG_W    = 2 * ACC_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  phasorPkg::strobe_t         strobes,
  input  logic [IDX_W-1:0]           wrPtr,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic                       phasorValid,
  output logic signed [ACC_W-1:0]    phasorRe,
  output logic signed [ACC_W-1:0]    phasorIm,
  output logic [MAG_W-1:0]           magSq,
  output logic                       avgValid,
  output logic [MAG_W-1:0]           avgMagSq
);
  localparam int AVG_SHIFT = $clog2(AVG_LEN);
  localparam int HIST_W    = (AVG_SHIFT > 0) ? AVG_SHIFT : 1;
  localparam int SUM_W     = MAG_W + AVG_SHIFT;
  localparam logic signed [ACC_W-1:0] ACC_MAX =
    ACC_W'(longint'(N) * (longint'(1) << (SAMPLE_W - 1)) * longint'(2 ** (COEF_W - 1) - 1));

  logic signed [SAMPLE_W-1:0] sampleBuf [N];
  logic signed [SAMPLE_W:0]   diffReg;
  logic [IDX_W-1:0]           idxReg;
  logic signed [COEF_W-1:0]   cosVal, sinVal;
  logic signed [ACC_W-1:0]    prodRe, prodIm;
  logic signed [ACC_W-1:0]    accRe, accIm;
  logic signed [MAG_W-1:0]    sqRe, sqIm;
  logic [MAG_W-1:0]           histBuf [AVG_LEN];
  logic [HIST_W-1:0]          histPtr;
  logic [SUM_W-1:0]           runSum;

  phasorRom #(.N(N), .COEF_W(COEF_W), .IDX_W(IDX_W)) rom (
    .idx(idxReg), .cosVal(cosVal), .sinVal(sinVal));

  assign prodRe = diffReg * cosVal;
  assign prodIm = diffReg * sinVal;
  assign sqRe   = accRe * accRe;
  assign sqIm   = accIm * accIm;

  // stage 1: difference of newest and oldest, overwrite slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) sampleBuf[i] <= '0;
      diffReg <= '0; idxReg <= '0;
    end else if (strobes.clr) begin
      for (int i = 0; i < N; i++) sampleBuf[i] <= '0;
      diffReg <= '0; idxReg <= '0;
    end else if (strobes.take) begin
      diffReg          <= (SAMPLE_W+1)'(sampleIn) - (SAMPLE_W+1)'(sampleBuf[wrPtr]);
      sampleBuf[wrPtr] <= sampleIn;
      idxReg           <= wrPtr;
    end
  end

  // stage 2: recursive update, stage 3: publish
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accRe <= '0; accIm <= '0;
      phasorRe <= '0; phasorIm <= '0; magSq <= '0; phasorValid <= 1'b0;
    end else if (strobes.clr) begin
      accRe <= '0; accIm <= '0;
      phasorRe <= '0; phasorIm <= '0; magSq <= '0; phasorValid <= 1'b0;
    end else begin
      if (strobes.acc) begin
        accRe <= accRe + prodRe;
        accIm <= accIm - prodIm;
      end
      phasorValid <= strobes.mag;
      if (strobes.mag) begin
        phasorRe <= accRe;
        phasorIm <= accIm;
        magSq    <= $unsigned(sqRe) + $unsigned(sqIm);
      end
    end
  end

  // stage 4: boxcar over the last AVG_LEN squared magnitudes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < AVG_LEN; i++) histBuf[i] <= '0;
      histPtr <= '0; runSum <= '0; avgValid <= 1'b0;
    end else if (strobes.clr) begin
      for (int i = 0; i < AVG_LEN; i++) histBuf[i] <= '0;
      histPtr <= '0; runSum <= '0; avgValid <= 1'b0;
    end else begin
      avgValid <= strobes.avg & strobes.avgOk;
      if (strobes.avg) begin
        runSum           <= runSum + SUM_W'(magSq) - SUM_W'(histBuf[histPtr]);
        histBuf[histPtr] <= magSq;
        histPtr          <= histPtr + 1'b1;
      end
    end
  end

  assign avgMagSq = runSum[SUM_W-1:AVG_SHIFT];

  // R10
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accRe <= ACC_MAX) && (accRe >= -ACC_MAX) && (accIm <= ACC_MAX) && (accIm >= -ACC_MAX));

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clr |=> (!phasorValid && !avgValid && phasorRe == '0 && phasorIm == '0 && avgMagSq == '0));

  // R7
  avg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(phasorValid) && !$past(strobes.clr)) |-> $stable(avgMagSq));
endmodule

// File: rtl/slidingPhasor.sv
`timescale 1ns/1ps
module slidingPhasor #(
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 16,
  parameter int N        = 512,
  parameter int AVG_LEN  = N / 2,
  parameter int IDX_W    = $clog2(N),
  parameter int ACC_W    = SAMPLE_W + COEF_W + IDX_W - 1,
  parameter int MAG_W    = 2 * ACC_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clear,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic                       phasorValid,
  output logic signed [ACC_W-1:0]    phasorRe,
  output logic signed [ACC_W-1:0]    phasorIm,
  output logic [MAG_W-1:0]           magSq,
  output logic                       avgValid,
  output logic [MAG_W-1:0]           avgMagSq
);
  phasorPkg::strobe_t strobes;
  logic [IDX_W-1:0]   wrPtr;

  phasorCtrl #(.N(N), .AVG_LEN(AVG_LEN), .IDX_W(IDX_W)) ctrl (
    .clk(clk), .rstN(rstN), .clear(clear), .sampleValid(sampleValid),
    .strobes(strobes), .wrPtr(wrPtr));

  phasorDatapath #(.N(N), .AVG_LEN(AVG_LEN), .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W),
                   .IDX_W(IDX_W), .ACC_W(ACC_W), .MAG_W(MAG_W)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrPtr(wrPtr), .sampleIn(sampleIn),
    .phasorValid(phasorValid), .phasorRe(phasorRe), .phasorIm(phasorIm),
    .magSq(magSq), .avgValid(avgValid), .avgMagSq(avgMagSq));

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !clear) ##1 !clear ##1 !clear |=> phasorValid);

  // R6
  ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    phasorValid |-> ($past(sampleValid, 3) && !$past(clear, 3)));

  // R8
  avg_after_phasor_chk: assert property (@(posedge clk) disable iff (!rstN)
    avgValid |-> $past(phasorValid));
endmodule

// File: tb/slidingPhasor_test.sv
`timescale 1ns/1ps
module slidingPhasor_test;
  localparam int N = 512;
  localparam int HALF = N / 2;
  localparam int QN = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clear = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [15:0] sampleIn = '0;
  logic phasorValid, avgValid;
  logic signed [39:0] phasorRe, phasorIm;
  logic [79:0] magSq, avgMagSq;

  slidingPhasor uut (.clk(clk), .rstN(rstN), .clear(clear), .sampleValid(sampleValid),
    .sampleIn(sampleIn), .phasorValid(phasorValid), .phasorRe(phasorRe),
    .phasorIm(phasorIm), .magSq(magSq), .avgValid(avgValid), .avgMagSq(avgMagSq));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  int cTab [N];
  int sTab [N];
  int win  [N];
  logic [127:0] hist [HALF];
  logic [127:0] avgSum;
  int nSamp, histPtr;

  logic signed [127:0] expRe [QN];
  logic signed [127:0] expIm [QN];
  logic [127:0] expMag [QN];
  logic [127:0] expAvg [QN];
  bit expFull [QN];
  int wrIdx = 0, rdIdx = 0;
  bit avgPending = 0;
  logic [127:0] pendAvg;
  bit pendFull;

  function automatic int roundQ(real v);
    real s = v * 32767.0;
    return (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(-s + 0.5);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int k = 0; k < N; k++) win[k] = 0;
    for (int k = 0; k < HALF; k++) hist[k] = '0;
    avgSum = '0; nSamp = 0; histPtr = 0; wrIdx = 0; rdIdx = 0; avgPending = 0;
  endtask

  task automatic modelPush(input int x);
    logic signed [127:0] re, im;
    logic [127:0] m;
    win[nSamp % N] = x;
    re = '0; im = '0;
    for (int k = 0; k < N; k++) begin
      re = re + 128'(longint'(win[k]) * longint'(cTab[k]));
      im = im - 128'(longint'(win[k]) * longint'(sTab[k]));
    end
    m = re * re + im * im;
    avgSum = avgSum + m - hist[histPtr];
    hist[histPtr] = m;
    histPtr = (histPtr + 1) % HALF;
    nSamp++;
    expRe[wrIdx % QN] = re; expIm[wrIdx % QN] = im; expMag[wrIdx % QN] = m;
    expAvg[wrIdx % QN] = avgSum >> $clog2(HALF);
    expFull[wrIdx % QN] = (nSamp >= N + HALF);
    wrIdx++;
  endtask

  // drive at a falling edge; returns at the next falling edge
  task automatic send(input int x);
    sampleValid = 1'b1; sampleIn = 16'(x);
    modelPush(x);
    @(negedge clk);
    sampleValid = 1'b0; sampleIn = 16'($urandom);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      sampleIn = 16'($urandom);
      @(negedge clk);
    end
  endtask

  // monitor: R2 R3 R4 R5 R7 R8
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (avgPending) begin
        chk(avgValid == pendFull, "R8 avgValid", 128'(avgValid), 128'(pendFull));
        chk(128'(avgMagSq) == pendAvg, "R7 avgMagSq", 128'(avgMagSq), pendAvg);
      end else if (avgValid) begin
        chk(1'b0, "R8 avgValid without phasor", 1, 0);
      end
      avgPending = 0;
      if (phasorValid) begin
        if (rdIdx >= wrIdx) chk(1'b0, "R6 unexpected phasorValid", 1, 0);
        else begin
          logic signed [127:0] aRe, aIm;
          aRe = phasorRe; aIm = phasorIm;
          chk(aRe == expRe[rdIdx % QN], "R2 phasorRe", aRe, expRe[rdIdx % QN]);
          chk(aIm == expIm[rdIdx % QN], "R3 phasorIm", aIm, expIm[rdIdx % QN]);
          chk(128'(magSq) == expMag[rdIdx % QN], "R4 magSq", 128'(magSq), expMag[rdIdx % QN]);
          pendAvg = expAvg[rdIdx % QN]; pendFull = expFull[rdIdx % QN];
          avgPending = 1;
          rdIdx++;
        end
      end
    end
  end

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < N; k++) begin
      cTab[k] = roundQ($cos(6.283185307179586 * k / N));
      sTab[k] = roundQ($sin(6.283185307179586 * k / N));
    end
    modelReset();
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(!phasorValid && !avgValid && phasorRe == 0 && phasorIm == 0 && magSq == 0 && avgMagSq == 0,
        "R1 reset outputs", 128'({phasorValid, avgValid}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!phasorValid && !avgValid && avgMagSq == 0, "R1 after release", 128'({phasorValid, avgValid}), 0);

    // directed single sample, then latency check R5
    send(12345);
    @(negedge clk);
    chk(phasorValid == 1'b0, "R5 not yet valid", 128'(phasorValid), 0);
    @(negedge clk);
    chk(phasorValid == 1'b1, "R5 valid after two edges", 128'(phasorValid), 1);
    idle(3);

    // random values, random gaps and back-to-back
    for (int i = 0; i < 500; i++) begin
      send(int'($signed(16'($urandom))));
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end
    // off-nominal sinusoid back to back
    for (int i = 0; i < 400; i++)
      send($rtoi(20000.0 * $cos(6.283185307179586 * i * 1.01 / N + 0.3)));
    idle(6);
    chk(rdIdx == wrIdx, "R5 all results seen", 128'(rdIdx), 128'(wrIdx));

    // R6: garbage with valid low leaves everything unchanged
    begin
      logic signed [39:0] hRe;
      logic [79:0] hAvg;
      hRe = phasorRe; hAvg = avgMagSq;
      idle(20);
      chk(phasorRe == hRe && avgMagSq == hAvg, "R6 outputs hold", 128'(phasorRe), 128'(hRe));
      chk(rdIdx == wrIdx, "R6 no extra result", 128'(rdIdx), 128'(wrIdx));
    end

    // R9: clear with a sample in the same cycle
    clear = 1'b1; sampleValid = 1'b1; sampleIn = 16'sd999;
    @(negedge clk);
    clear = 1'b0; sampleValid = 1'b0;
    modelReset();
    chk(phasorRe == 0 && phasorIm == 0 && magSq == 0 && avgMagSq == 0 && !avgValid,
        "R9 cleared outputs", 128'(avgMagSq), 0);
    idle(4);
    chk(rdIdx == 0, "R9 dropped sample", 128'(rdIdx), 0);
    send(1000);   // must land in slot 0
    idle(5);
    chk(rdIdx == 1, "R9 restart slot 0", 128'(rdIdx), 1);

    // R10: full-scale aligned with the cosine table
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    modelReset();
    for (int k = 0; k < N + 40; k++)
      send((cTab[k % N] >= 0) ? 32767 : -32768);
    idle(6);
    chk(rdIdx == wrIdx, "R10 full scale results", 128'(rdIdx), 128'(wrIdx));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule